// File: doc/BRIEF.md
# Electrically Erasable EPROM Core

This block is a synthesizable behavioural stand-in for a byte-wide, electrically erasable, read-mostly memory array. It is the device under test for programmer logic: a programmer drives the active-low chip select, output select and write strobe, the address and a write byte. It also drives three decoded supply-condition flags: program supply present, erase supply present, and identifier high voltage present on the identifier address line. The core answers with read data and a drive-enable indication that stands in for a three-state bus.

Writes are one-directional. A program operation can only clear bits, because the stored byte becomes the bitwise AND of the old and new values. An erase is the only way back to ones, and it always sets the entire array to `8'hFF` at once. Program and erase commit on the rising edge of the write strobe, which the core samples on `clk`. The cell update is visible in the cycle after the clock edge that sees the strobe high again. The operating mode is decoded from the pin and flag combination. The core also has a built-in two-byte identifier read, and it has an error flag for the illegal case in which both supply flags are asserted.

Top module: `eprom_core`

## Requirements
- R1: After reset every byte reads `8'hFF`, `dout_oe` is low while `ce_n` or `oe_n` is high, and `supply_err` is low.
- R2: With `ce_n`=0, `oe_n`=0 and no supply flag and no `id_hv`, `dout_oe` is 1 and `dout` equals the byte stored at `addr` (combinational read).
- R3: With `ce_n`=1, `dout_oe` is 0 and `dout` is `8'h00` whatever `oe_n`, `pgm_n` and the flags are, and no strobe changes the array.
- R4: With `ce_n`=0 and `oe_n`=1, `dout_oe` is 0 and `dout` is `8'h00`.
- R5: A program commit needs `prog_supply`=1, `erase_supply`=0, `ce_n`=0 and `oe_n`=1 at the clock edge where `pgm_n` is seen high after being seen low. The byte at `addr` then takes the new value, which reads back from the next cycle on.
- R6: Programming only clears bits: the new stored byte is the old byte AND `din`.
- R7: An erase commit needs `erase_supply`=1, `prog_supply`=0, `id_hv`=1, `addr[0]`=0, `ce_n`=0 and `oe_n`=1 at the strobe rising edge, and it sets every byte to `8'hFF`.
- R8: An erase-supply strobe with `addr[0]`=1 or with `id_hv`=0 changes nothing.
- R9: With `id_hv`=1, no supply flag, and `ce_n`=0 and `oe_n`=0, `dout` is `8'hDA` when `addr[0]`=0 and `8'h01` when `addr[0]`=1.
- R10: With either supply flag asserted and `ce_n`=0 and `oe_n`=0, `dout` returns the array byte, even when `id_hv`=1.
- R11: With both supply flags asserted, a strobe changes nothing. A strobe taken with `ce_n`=0 sets `supply_err`, and it stays set until reset.
- R12: A strobe with `oe_n`=0, or with no supply flag, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; fills the array with ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output select, active low |
| pgm_n | input | 1 | Write strobe, active low; commits on its rising edge |
| addr | input | AW | Byte address, AW = clog2(DEPTH) |
| din | input | 8 | Byte to program |
| prog_supply | input | 1 | Program supply present |
| erase_supply | input | 1 | Erase supply present |
| id_hv | input | 1 | Identifier high voltage present on identifier address line |
| dout | output | 8 | Read data, zero when not driven |
| dout_oe | output | 1 | Read data drive enable (low means high impedance) |
| supply_err | output | 1 | Sticky flag: strobe seen with both supplies asserted |

## Verification
The bench keeps a reference image of the array and goes after the cases where a loose decoder would write the array. A strobe with chip select high, with output select low, with no supply, with both supplies, or with an erase supply but `addr[0]` high or `id_hv` low must leave every byte unchanged; a design that got any of these wrong would show a changed byte on the full read-back sweep. Programming over already programmed bytes exposes a design that stores `din` instead of the AND, because it would bring back ones. The identifier sweep, and the verify read with `id_hv` still high, catch a design that gives the wrong priority to identifier or array data.

// File: rtl/eprom_core_pkg.sv
package eprom_core_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ID_CODE_EVEN = 8'hDA;
  localparam logic [BYTE_W-1:0] ID_CODE_ODD  = 8'h01;
  localparam logic [BYTE_W-1:0] ERASED_BYTE  = 8'hFF;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_READ,
    M_IDENT,
    M_VERIFY,
    M_PROG,
    M_ERASE,
    M_HOLD,
    M_ILLEGAL
  } core_mode_e;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_core_pkg::*;
(
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       prog_sup,
  input  logic       erase_sup,
  input  logic       id_hv,
  input  logic       a0,
  output core_mode_e mode
);

  always_comb begin
    if (ce_n) begin
      mode = M_STANDBY;
    end else if (prog_sup && erase_sup) begin
      mode = M_ILLEGAL;
    end else if (!oe_n) begin
      if (prog_sup || erase_sup) mode = M_VERIFY;
      else if (id_hv)            mode = M_IDENT;
      else                       mode = M_READ;
    end else if (erase_sup) begin
      mode = (id_hv && !a0) ? M_ERASE : M_HOLD;
    end else if (prog_sup) begin
      mode = M_PROG;
    end else begin
      mode = M_HOLD;
    end
  end

endmodule

// File: rtl/eprom_strobe_edge.sv
module eprom_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  output logic commit
);

  logic pgm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm_n;
  end

  assign commit = pgm_n && !pgm_q;

  // R5: a commit lasts exactly one cycle per strobe
  p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_core_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic              erase_we,
  input  logic [AW-1:0]     wa,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     ra,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] old_byte;

  assign old_byte = mem[wa];
  assign rdata    = mem[ra];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (erase_we) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (prog_we) begin
      mem[wa] <= old_byte & wdata;
    end
  end

  // R6: programming can only clear bits
  p_prog_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we && !erase_we |=> mem[$past(wa)] == ($past(old_byte) & $past(wdata)));

  // R7: erase brings both ends of the array to ones
  p_erase_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |=> (mem[0] == ERASED_BYTE) && (mem[DEPTH-1] == ERASED_BYTE));

endmodule

// File: rtl/eprom_out_mux.sv
module eprom_out_mux
  import eprom_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  core_mode_e        mode,
  input  logic              a0,
  input  logic [BYTE_W-1:0] arr_data,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_oe
);

  logic [BYTE_W-1:0] sel_data;

  assign dout_oe  = !ce_n && !oe_n;
  assign sel_data = (mode == M_IDENT) ? (a0 ? ID_CODE_ODD : ID_CODE_EVEN) : arr_data;
  assign dout     = dout_oe ? sel_data : '0;

  // R3: deselected chip never drives
  p_standby_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STANDBY) |-> !dout_oe && (dout == '0));

  // R4: output select high blocks the bus
  p_oe_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_oe);

endmodule

// File: rtl/eprom_core.sv
module eprom_core
  import eprom_core_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] din,
  input  logic              prog_supply,
  input  logic              erase_supply,
  input  logic              id_hv,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_oe,
  output logic              supply_err
);

  core_mode_e        mode;
  logic              commit;
  logic              prog_we;
  logic              erase_we;
  logic [BYTE_W-1:0] arr_data;

  eprom_mode_dec u_dec (
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .prog_sup  (prog_supply),
    .erase_sup (erase_supply),
    .id_hv     (id_hv),
    .a0        (addr[0]),
    .mode      (mode)
  );

  eprom_strobe_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pgm_n  (pgm_n),
    .commit (commit)
  );

  assign prog_we  = commit && (mode == M_PROG);
  assign erase_we = commit && (mode == M_ERASE);

  eprom_cell_array #(.DEPTH(DEPTH)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_we  (prog_we),
    .erase_we (erase_we),
    .wa       (addr),
    .wdata    (din),
    .ra       (addr),
    .rdata    (arr_data)
  );

  eprom_out_mux u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .mode     (mode),
    .a0       (addr[0]),
    .arr_data (arr_data),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          supply_err <= 1'b0;
    else if (commit && mode == M_ILLEGAL) supply_err <= 1'b1;
  end

  // R11: both supplies together never write
  p_both_inhibit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_supply && erase_supply) |-> !prog_we && !erase_we);

  // R11: error flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    supply_err |=> supply_err);

  // R3: deselected chip never writes
  p_ce_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !prog_we && !erase_we);

endmodule

// File: tb/tb_eprom_core.sv
module tb_eprom_core;

  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic prog_supply = 1'b0, erase_supply = 1'b0, id_hv = 1'b0;
  logic [7:0] dout;
  logic dout_oe, supply_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  eprom_core #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .addr(addr), .din(din), .prog_supply(prog_supply), .erase_supply(erase_supply),
    .id_hv(id_hv), .dout(dout), .dout_oe(dout_oe), .supply_err(supply_err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setctl(input logic c, input logic o, input logic ps, input logic es,
                        input logic hv, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; prog_supply = ps; erase_supply = es; id_hv = hv; addr = a; din = d;
  endtask

  task automatic strobe();
    @(negedge clk) pgm_n = 1'b0;
    @(negedge clk) pgm_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      setctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AW'(a), 8'h00);
      #2;
      check(req, dout, model[a]);
      check(req, {7'd0, dout_oe}, 8'd1);
    end
    setctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1: reset state
    check("R1", {7'd0, dout_oe}, 8'd0);
    check("R1", {7'd0, supply_err}, 8'd0);
    read_all("R1");

    // R5: program each byte
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] p;
      p = 8'((a * 37) ^ 8'h5A);
      setctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, AW'(a), p);
      strobe();
      model[a] = model[a] & p;
    end
    read_all("R5");

    // R6: second pass only clears bits
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] p;
      p = ~8'(a * 11);
      setctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, AW'(a), p);
      strobe();
      model[a] = model[a] & p;
    end
    read_all("R6");

    // R3: deselected chip: no drive, strobes inhibited
    setctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, AW'(3), 8'h00);
    #2;
    check("R3", {7'd0, dout_oe}, 8'd0);
    check("R3", dout, 8'h00);
    setctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, AW'(3), 8'h00);
    strobe();
    setctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, AW'(0), 8'h00);
    strobe();
    read_all("R3");

    // R4: output select high
    setctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(5), 8'h00);
    #2;
    check("R4", {7'd0, dout_oe}, 8'd0);
    check("R4", dout, 8'h00);

    // R12: strobe with oe low or without supply
    setctl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(6), 8'h00);
    strobe();
    setctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(7), 8'h00);
    strobe();
    setctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, AW'(8), 8'h00);
    strobe();
    read_all("R12");

    // R8: erase blocked by addr[0]=1 or id_hv=0
    setctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, AW'(1), 8'hFF);
    strobe();
    setctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(0), 8'hFF);
    strobe();
    read_all("R8");

    // R11: both supplies
    check("R11", {7'd0, supply_err}, 8'd0);
    setctl(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, AW'(0), 8'h00);
    strobe();
    #2;
    check("R11", {7'd0, supply_err}, 8'd1);
    read_all("R11");
    repeat (5) @(negedge clk);
    check("R11", {7'd0, supply_err}, 8'd1);

    // R9: identifier sweep
    for (int a = 0; a < DEPTH; a++) begin
      setctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, AW'(a), 8'h00);
      #2;
      check("R9", dout, (a % 2 == 1) ? 8'h01 : 8'hDA);
    end

    // R10: verify read with supply overrides identifier
    for (int a = 0; a < DEPTH; a++) begin
      setctl(1'b0, 1'b0, (a % 2 == 0), (a % 2 == 1), 1'b1, AW'(a), 8'h00);
      #2;
      check("R10", dout, model[a]);
    end

    // R7: erase
    setctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, AW'(0), 8'h00);
    strobe();
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    read_all("R7");

    // R2: plain read after a fresh program following erase
    setctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, AW'(DEPTH - 1), 8'h3C);
    strobe();
    model[DEPTH-1] = 8'h3C;
    read_all("R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule